// File: doc/BRIEF.md
# Addressed Dual-Bank PWM Generator

This block drives sixteen pulse-width modulated lines arranged as two banks of eight. Every line owns a 10-bit duty register. One shared 10-bit period counter is stepped by a tick from a programmable prescaler. Each line compares its duty against that counter: the line is low while the count is above the duty and high otherwise. The prescaler divides the clock by R, where R is the 4-bit divider code plus one, so R runs from 1 to 16.

A control write is a single-cycle strobe. It carries a 3-bit slot index, one duty value for bank A, one for bank B, a brightness level for each bank and the divider code. Both duty values land in the same slot index of their banks. They wait in a staging register and move into the active register only when the counter wraps, so a period is never cut short or stretched. A clock enable can freeze the timebase. A force-off input, meant to be driven by a fault detector, pulls all sixteen lines low at once and leaves the stored state untouched. The two brightness codes are passed out as level fields for an analog scaler outside this block.

Top module: `dual_bank_pwm`

## Requirements
- R1: While and after reset the counter is 0, the divider code is 0, every staged and active duty is 0 and both level outputs are 0. With force_off low, every PWM line is therefore high, because a count of 0 is not greater than a duty of 0.
- R2: A cycle with wr_en high stores duty_a into staged slot wr_addr of bank A and duty_b into staged slot wr_addr of bank B. All other slots keep their values. Line i of pwm_a or pwm_b (bit i) belongs to slot i.
- R3: Staged duties are copied to the active duties only on the tick that takes the counter from 1023 to 0. A write that comes mid-period leaves the outputs of the current period unchanged. If a write and the wrap fall in the same cycle, the wrap copies the staged values held before that write.
- R4: A line is low when the counter value is strictly greater than its active duty and high otherwise. A duty of 1023 keeps the line high for the whole period; a duty of 0 makes it high only at count 0.
- R5: The counter advances by exactly one on each tick and wraps from 1023 to 0, so a period is 1024 ticks.
- R6: A tick occurs on every R-th enabled cycle, with R = stored divider code + 1. The divider code is captured from div_code on a write. If a new code is lower than the current prescaler phase, the next enabled cycle ticks.
- R7: While clk_en is low, the prescaler and the counter hold their values. Writes are still accepted.
- R8: While force_off is high, all sixteen lines are low in the same cycle. The counter and the duties carry on unaffected, and the lines resume as soon as force_off falls.
- R9: level_a and level_b present the bright_a and bright_b codes of the last write. A code k stands for k/16 of full scale, so the range runs from 0 to 15/16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Timebase enable |
| force_off | input | 1 | Drives all PWM lines low |
| wr_en | input | 1 | Control write strobe |
| wr_addr | input | 3 | Slot index written in both banks |
| duty_a | input | 10 | Duty for bank A slot |
| duty_b | input | 10 | Duty for bank B slot |
| bright_a | input | 4 | Bank A level code |
| bright_b | input | 4 | Bank B level code |
| div_code | input | 4 | Prescaler code, divide by code+1 |
| pwm_a | output | 8 | Bank A PWM lines, bit i is slot i |
| pwm_b | output | 8 | Bank B PWM lines, bit i is slot i |
| level_a | output | 4 | Bank A brightness level |
| level_b | output | 4 | Bank B brightness level |

## Verification
The bench goes after the extreme duties 0 and 1023. An off-by-one comparator would leave a line dark at count 0 or drop it low at the top of the period. It writes in the middle of a period and checks the output: a design without staging would change the waveform at once instead of at the wrap. It changes the divider from 3 to 15 and then down to 1 while the prescaler is mid-phase. A prescaler that compares for equality would then stall for up to 16 cycles. It also holds clk_en low and pulses force_off, which catches a counter that keeps running or a fault gate that corrupts the stored duties.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int unsigned PWM_SLOTS  = 8;
    localparam int unsigned PWM_DUTY_W = 10;
    localparam int unsigned PWM_DIV_W  = 4;
    localparam int unsigned PWM_LVL_W  = 4;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] code,
    output logic             tick
);
    logic [DIV_W-1:0] phase_d, phase_q;

    always_comb begin
        // >= rather than == so a lowered code never skips past its match
        tick    = en && (phase_q >= code);
        phase_d = phase_q;
        if (en) begin
            phase_d = tick ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned DUTY_W = 10,
    parameter int unsigned AW     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DUTY_W-1:0]       wr_duty,
    input  logic                    load,
    input  logic [DUTY_W-1:0]       count,
    input  logic                    force_off,
    output logic [SLOTS-1:0]        pwm,
    output logic [SLOTS*DUTY_W-1:0] act_flat,
    output logic [SLOTS*DUTY_W-1:0] pend_flat
);
    typedef struct packed {
        logic [SLOTS-1:0][DUTY_W-1:0] pend;
        logic [SLOTS-1:0][DUTY_W-1:0] act;
    } slots_t;

    slots_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // staged values taken before this cycle's write
        if (load)  st_d.act = st_q.pend;
        if (wr_en) st_d.pend[wr_addr] = wr_duty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign pwm[g] = ~force_off & (count <= st_q.act[g]);
    end

    assign act_flat  = st_q.act;
    assign pend_flat = st_q.pend;
endmodule

// File: rtl/dual_bank_pwm.sv
module dual_bank_pwm
    import pwm_pkg::*;
#(
    parameter int unsigned SLOTS  = PWM_SLOTS,
    parameter int unsigned DUTY_W = PWM_DUTY_W,
    parameter int unsigned DIV_W  = PWM_DIV_W,
    parameter int unsigned LVL_W  = PWM_LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              force_off,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DUTY_W-1:0] duty_a,
    input  logic [DUTY_W-1:0] duty_b,
    input  logic [LVL_W-1:0]  bright_a,
    input  logic [LVL_W-1:0]  bright_b,
    input  logic [DIV_W-1:0]  div_code,
    output logic [SLOTS-1:0]  pwm_a,
    output logic [SLOTS-1:0]  pwm_b,
    output logic [LVL_W-1:0]  level_a,
    output logic [LVL_W-1:0]  level_b
);
    localparam int unsigned      AW      = 3;
    localparam logic [DUTY_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
        logic [DIV_W-1:0]  div;
        logic [LVL_W-1:0]  lvl_a;
        logic [LVL_W-1:0]  lvl_b;
    } ctl_t;

    ctl_t                    st_d, st_q;
    logic                    tick;
    logic                    wrap;
    logic [DUTY_W-1:0]       count;
    logic [SLOTS*DUTY_W-1:0] act_a_flat, pend_a_flat;
    logic [SLOTS*DUTY_W-1:0] act_b_flat, pend_b_flat;

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (clk_en),
        .code (st_q.div),
        .tick (tick)
    );

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == CNT_TOP);
        if (tick) st_d.cnt = st_q.cnt + 1'b1;
        if (wr_en) begin
            st_d.div   = div_code;
            st_d.lvl_a = bright_a;
            st_d.lvl_b = bright_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign level_a = st_q.lvl_a;
    assign level_b = st_q.lvl_b;

    pwm_bank #(.SLOTS(SLOTS), .DUTY_W(DUTY_W), .AW(AW)) u_bank_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_duty  (duty_a),
        .load     (wrap),
        .count    (count),
        .force_off(force_off),
        .pwm      (pwm_a),
        .act_flat (act_a_flat),
        .pend_flat(pend_a_flat)
    );

    pwm_bank #(.SLOTS(SLOTS), .DUTY_W(DUTY_W), .AW(AW)) u_bank_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_duty  (duty_b),
        .load     (wrap),
        .count    (count),
        .force_off(force_off),
        .pwm      (pwm_b),
        .act_flat (act_b_flat),
        .pend_flat(pend_b_flat)
    );
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned DUTY_W = 10,
    parameter int unsigned DIV_W  = 4,
    parameter int unsigned LVL_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clk_en,
    input logic                    force_off,
    input logic                    wr_en,
    input logic [2:0]              wr_addr,
    input logic [DUTY_W-1:0]       duty_a,
    input logic [DUTY_W-1:0]       duty_b,
    input logic [LVL_W-1:0]        bright_a,
    input logic [LVL_W-1:0]        bright_b,
    input logic                    tick,
    input logic                    wrap,
    input logic [DUTY_W-1:0]       count,
    input logic [SLOTS*DUTY_W-1:0] pend_a,
    input logic [SLOTS*DUTY_W-1:0] pend_b,
    input logic [SLOTS*DUTY_W-1:0] act_a,
    input logic [SLOTS*DUTY_W-1:0] act_b,
    input logic [SLOTS-1:0]        pwm_a,
    input logic [SLOTS-1:0]        pwm_b,
    input logic [LVL_W-1:0]        level_a,
    input logic [LVL_W-1:0]        level_b
);
    localparam int unsigned GAP_LIM = 1 << DIV_W;

    logic [DIV_W:0]      gap_q;
    logic                wr_seen_q;
    logic [2:0]          addr_cap_q;
    logic [DUTY_W-1:0]   da_cap_q, db_cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q      <= '0;
            wr_seen_q  <= 1'b0;
            addr_cap_q <= '0;
            da_cap_q   <= '0;
            db_cap_q   <= '0;
        end else begin
            if (tick)        gap_q <= '0;
            else if (clk_en) gap_q <= gap_q + 1'b1;
            wr_seen_q  <= wr_en;
            addr_cap_q <= wr_addr;
            da_cap_q   <= duty_a;
            db_cap_q   <= duty_b;
        end
    end

    a_r2_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seen_q |-> (pend_a[addr_cap_q*DUTY_W +: DUTY_W] == da_cap_q) &&
                      (pend_b[addr_cap_q*DUTY_W +: DUTY_W] == db_cap_q));

    a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act_a) && $stable(act_b));

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count == $past(count) + 1'b1);

    a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < GAP_LIM);

    a_r7_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(count));

    a_r8_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |-> (pwm_a == '0) && (pwm_b == '0));

    a_r9_level_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (level_a == $past(bright_a)) && (level_b == $past(bright_b)));
endmodule

bind dual_bank_pwm pwm_checker #(
    .SLOTS(SLOTS), .DUTY_W(DUTY_W), .DIV_W(DIV_W), .LVL_W(LVL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .force_off(force_off),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .duty_a   (duty_a),
    .duty_b   (duty_b),
    .bright_a (bright_a),
    .bright_b (bright_b),
    .tick     (tick),
    .wrap     (wrap),
    .count    (count),
    .pend_a   (pend_a_flat),
    .pend_b   (pend_b_flat),
    .act_a    (act_a_flat),
    .act_b    (act_b_flat),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b),
    .level_a  (level_a),
    .level_b  (level_b)
);

// File: tb/sim_dual_bank_pwm.sv
`timescale 1ns/1ps
module sim_dual_bank_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       force_off = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [9:0] duty_a = '0, duty_b = '0;
    logic [3:0] bright_a = '0, bright_b = '0, div_code = '0;
    logic [7:0] pwm_a, pwm_b;
    logic [3:0] level_a, level_b;

    always #4 clk = ~clk;

    dual_bank_pwm u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .force_off(force_off),
        .wr_en(wr_en), .wr_addr(wr_addr), .duty_a(duty_a), .duty_b(duty_b),
        .bright_a(bright_a), .bright_b(bright_b), .div_code(div_code),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .level_a(level_a), .level_b(level_b)
    );

    typedef struct {
        logic [7:0] pa;
        logic [7:0] pb;
        logic [3:0] la;
        logic [3:0] lb;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    // requirement-level reference model
    int m_pre, m_cnt, m_div, m_la, m_lb;
    int m_pend_a[8], m_pend_b[8], m_act_a[8], m_act_b[8];

    always @(posedge clk) begin
        exp_t e;
        bit   tk;
        if (!rst_n) begin  // R1
            m_pre = 0; m_cnt = 0; m_div = 0; m_la = 0; m_lb = 0;
            for (int i = 0; i < 8; i++) begin
                m_pend_a[i] = 0; m_pend_b[i] = 0; m_act_a[i] = 0; m_act_b[i] = 0;
            end
        end else begin
            tk = clk_en && (m_pre >= m_div);            // R6
            if (clk_en) m_pre = tk ? 0 : m_pre + 1;      // R7
            if (tk && m_cnt == 1023) begin               // R3
                for (int i = 0; i < 8; i++) begin
                    m_act_a[i] = m_pend_a[i];
                    m_act_b[i] = m_pend_b[i];
                end
            end
            if (tk) m_cnt = (m_cnt + 1) % 1024;          // R5
            if (wr_en) begin                             // R2, R9
                m_pend_a[wr_addr] = duty_a;
                m_pend_b[wr_addr] = duty_b;
                m_div = div_code; m_la = bright_a; m_lb = bright_b;
            end
        end
        for (int i = 0; i < 8; i++) begin                // R4
            e.pa[i] = (m_cnt <= m_act_a[i]);
            e.pb[i] = (m_cnt <= m_act_b[i]);
        end
        e.la = m_la[3:0];
        e.lb = m_lb[3:0];
        sb_q.push_back(e);
    end

    // monitor: pops one expected item per cycle, samples at the falling edge
    always @(negedge clk) begin
        exp_t e;
        logic [7:0] xa, xb;
        if (!done && sb_q.size() > 0) begin
            e  = sb_q.pop_front();
            xa = force_off ? 8'h00 : e.pa;   // R8
            xb = force_off ? 8'h00 : e.pb;
            checks++;
            if (pwm_a !== xa || pwm_b !== xb) begin
                fails++;
                $display("FAIL %s pwm: actual a=%h b=%h expected a=%h b=%h at %0t",
                         phase, pwm_a, pwm_b, xa, xb, $time);
            end
            checks++;
            if (level_a !== e.la || level_b !== e.lb) begin
                fails++;
                $display("FAIL %s level: actual a=%h b=%h expected a=%h b=%h",
                         phase, level_a, level_b, e.la, e.lb);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic write(input logic [2:0] a, input logic [9:0] da, input logic [9:0] db,
                         input logic [3:0] ba, input logic [3:0] bb, input logic [3:0] dv);
        wr_en = 1'b1; wr_addr = a; duty_a = da; duty_b = db;
        bright_a = ba; bright_b = bb; div_code = dv;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        step(5);
        phase = "R1";
        rst_n = 1'b1;
        step(3);
        // R2 R4 extremes: slot0 A=0 B=1023, slot7 A=1023 B=0, slot3 mid
        phase = "R2";
        write(3'd0, 10'd0,    10'd1023, 4'd5,  4'd15, 4'd0);
        write(3'd7, 10'd1023, 10'd0,    4'd5,  4'd15, 4'd0);
        write(3'd3, 10'd512,  10'd100,  4'd0,  4'd15, 4'd0);
        phase = "R4";
        step(1100);
        // R3 mid-period write must wait for wrap
        phase = "R3";
        step(200);
        write(3'd3, 10'd200, 10'd900, 4'd9, 4'd1, 4'd0);
        step(1100);
        // R8 force off pulses
        phase = "R8";
        force_off = 1'b1; step(30);
        force_off = 1'b0; step(20);
        force_off = 1'b1; step(3);
        force_off = 1'b0; step(10);
        // R7 hold timebase, write still accepted
        phase = "R7";
        clk_en = 1'b0; step(20);
        write(3'd5, 10'd300, 10'd700, 4'd2, 4'd3, 4'd0);
        step(30);
        clk_en = 1'b1; step(1100);
        // R6 divider changes
        phase = "R6";
        write(3'd1, 10'd64, 10'd960, 4'd2, 4'd3, 4'd3);
        step(4200);
        write(3'd2, 10'd1, 10'd1022, 4'd2, 4'd3, 4'd15);
        step(37);
        write(3'd2, 10'd1, 10'd1022, 4'd2, 4'd3, 4'd1);
        step(2200);
        // R5 R9 sweep all slots at divide-by-1
        phase = "R5";
        for (int s = 0; s < 8; s++) begin
            write(3'(s), 10'(s * 131), 10'(1023 - s * 97), 4'(s), 4'(15 - s), 4'd0);
        end
        phase = "R9";
        step(2100);
        phase = "R1";
        rst_n = 1'b0; step(3);
        rst_n = 1'b1; step(5);
        finish_run();
    end
endmodule